// File: doc/BRIEF.md
# Programmable Odd-Duty Clock Divider

This block is a post-scale clock divider for a clock-generation path. It divides an input clock by the sum of two programmable counts: one for the time the output spends high and one for the time it spends low. Both counts are 8 bits wide. A count of zero stands for 256. A bypass control sends the input clock straight to the output. An odd-duty control moves the falling output edge half an input period earlier. With that control set, odd divide ratios can still give an exact 50% duty cycle. For example, a high count of 2 and a low count of 1 gives 1.5 cycles high and 1.5 cycles low at divide-by-3.

The counts and the odd-duty control are sampled only when an output period begins. Software or a configuration chain can therefore change them at any time without a runt pulse. The half-cycle edge comes from one flop clocked on the falling edge of the input clock. Every other register runs on the rising edge.

Top module: `odd_div_clkgen`

## Requirements
- R1: While the synchronous reset is sampled high, the divided output is low. This holds at every point of the input clock, including a reset asserted in the middle of a period.
- R2: On the first rising input edge after reset is released, a new output period starts and the output goes high.
- R3: With odd-duty clear, the output stays high for exactly the high count in input cycles. Both output edges coincide with rising input edges.
- R4: The output period is the high count plus the low count, in input cycles. A count field of value 0 counts as 256.
- R5: With odd-duty set, the falling output edge happens on the falling input edge in the middle of the last high cycle. The high time is 0.5 cycle shorter and the low time is 0.5 cycle longer. The rising output edge still falls on a rising input edge.
- R6: With odd-duty set, a high count of 2 and a low count of 1 gives 1.5 cycles high and 1.5 cycles low, which is 50% duty at divide-by-3.
- R7: A change to the high count, low count or odd-duty control during a period has no effect on that period. The new values apply from the next period start.
- R8: A change presented in the last input cycle of a period takes effect in the period that begins at the next rising edge.
- R9: With bypass set, the output equals the input clock. It is high in the first half of each input cycle and low in the second half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| hi_set | input | 8 | High-time count in input cycles (0 means 256) |
| lo_set | input | 8 | Low-time count in input cycles (0 means 256) |
| odd_set | input | 1 | Move the falling output edge half a cycle early |
| bypass | input | 1 | Pass the input clock straight to the output |
| clk_out | output | 1 | Divided (or bypassed) clock |

## Verification
Two functions can fall in the same cycle. One is the end of an output period, which reloads the counts. The other is the arrival of new count settings from outside. To provoke the overlap, the bench changes the settings on the falling input edge just before the rising edge that starts the next period. It then expects that next period to follow the new values in full, while the period just ended follows the old values in full. The bench also changes settings deep inside a long period and expects no effect until that period ends. A third test asserts reset halfway through a running period.

// File: rtl/odd_div_pkg.sv
package odd_div_pkg;

  // Effective length of a count field: value 0 stands for 2**cw.
  function automatic int unsigned eff_count(input int unsigned raw, input int unsigned cw);
    return (raw == 0) ? (32'd1 << cw) : raw;
  endfunction

  // Output period in input cycles for one pair of count fields.
  function automatic int unsigned period_len(input int unsigned hi, input int unsigned lo,
                                             input int unsigned cw);
    return eff_count(hi, cw) + eff_count(lo, cw);
  endfunction

endpackage

// File: rtl/odd_div_phase_ctr.sv
module odd_div_phase_ctr
  import odd_div_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] hi_set,
  input  logic [CW-1:0] lo_set,
  input  logic          odd_set,
  output logic          hi_q,
  output logic          last_hi,
  output logic          odd_en,
  output logic          start_evt
);
  localparam int EW = CW + 1;
  localparam int RW = EW + 1;

  logic [EW-1:0] rem;
  logic [EW-1:0] lo_len;
  logic          restart;
  logic          fall_evt;

  // Named internal events
  assign start_evt = restart || (!hi_q && rem == EW'(1));
  assign fall_evt  = hi_q && rem == EW'(1);
  assign last_hi   = fall_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= 1'b0;
      restart <= 1'b1;
      rem     <= '0;
      lo_len  <= EW'(1);
      odd_en  <= 1'b0;
    end else if (start_evt) begin
      restart <= 1'b0;
      hi_q    <= 1'b1;
      rem     <= EW'(eff_count(32'(hi_set), CW));
      lo_len  <= EW'(eff_count(32'(lo_set), CW));
      odd_en  <= odd_set;
    end else if (fall_evt) begin
      hi_q <= 1'b0;
      rem  <= lo_len;
    end else begin
      rem <= rem - EW'(1);
    end
  end

  // ---- assertion support: independent run-length counter ----
  logic [RW-1:0] run_len;
  logic [RW-1:0] hi_len_chk;
  logic          rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      run_len    <= '0;
      hi_len_chk <= RW'(1);
    end else if (start_evt) begin
      run_len    <= RW'(1);
      hi_len_chk <= RW'(eff_count(32'(hi_set), CW));
    end else begin
      run_len <= run_len + RW'(1);
    end
  end

  always_comb begin
    if (rst_q) p_reset_low_r1: assert (!hi_q);
  end

  p_first_high_r2: assert property (@(posedge clk) disable iff (rst)
    restart |=> hi_q);

  p_high_len_r3: assert property (@(posedge clk) disable iff (rst)
    fall_evt |-> run_len == hi_len_chk);

  p_period_r4: assert property (@(posedge clk) disable iff (rst)
    (start_evt && !restart) |-> run_len == hi_len_chk + RW'(lo_len));

  p_load_at_start_r7: assert property (@(posedge clk) disable iff (rst)
    !start_evt |=> $stable(lo_len) && $stable(odd_en) && $stable(hi_len_chk));

endmodule

// File: rtl/odd_div_edge_trim.sv
module odd_div_edge_trim (
  input  logic clk,
  input  logic rst,
  input  logic hi_q,
  input  logic last_hi,
  input  logic odd_en,
  output logic div_out
);
  logic cut;

  // Falling-edge flop: ends the last high cycle half a period early
  always_ff @(negedge clk) begin
    cut <= !rst && odd_en && last_hi;
  end

  assign div_out = hi_q && !cut;

  p_cut_odd_only_r5: assert property (@(posedge clk) disable iff (rst)
    cut |-> (odd_en && hi_q));

  p_cut_single_r6: assert property (@(posedge clk) disable iff (rst)
    cut |=> !cut);

endmodule

// File: rtl/odd_div_clkgen.sv
module odd_div_clkgen #(
  parameter int CW = 8
) (
  input  logic          clk_in,
  input  logic          rst,
  input  logic [CW-1:0] hi_set,
  input  logic [CW-1:0] lo_set,
  input  logic          odd_set,
  input  logic          bypass,
  output logic          clk_out
);
  logic hi_q;
  logic last_hi;
  logic odd_en;
  logic start_evt;
  logic div_out;

  odd_div_phase_ctr #(.CW(CW)) u_ctr (
    .clk       (clk_in),
    .rst       (rst),
    .hi_set    (hi_set),
    .lo_set    (lo_set),
    .odd_set   (odd_set),
    .hi_q      (hi_q),
    .last_hi   (last_hi),
    .odd_en    (odd_en),
    .start_evt (start_evt)
  );

  odd_div_edge_trim u_trim (
    .clk     (clk_in),
    .rst     (rst),
    .hi_q    (hi_q),
    .last_hi (last_hi),
    .odd_en  (odd_en),
    .div_out (div_out)
  );

  assign clk_out = bypass ? clk_in : div_out;

  p_start_rises_r2: assert property (@(posedge clk_in) disable iff (rst)
    start_evt |=> hi_q);

endmodule

// File: tb/odd_div_clkgen_test.sv
module odd_div_clkgen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] hi_set = 8'd1;
  logic [7:0] lo_set = 8'd1;
  logic       odd_set = 1'b0;
  logic       bypass = 1'b0;
  logic       clk_out;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;   // 125 MHz

  odd_div_clkgen uut (
    .clk_in (clk), .rst (rst), .hi_set (hi_set), .lo_set (lo_set),
    .odd_set (odd_set), .bypass (bypass), .clk_out (clk_out)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: clk_out=%0b expected %0b", tag, $time, act, exp);
    end
  endtask

  // Expected half-cycle samples for one output period, computed from the rules
  task automatic push_period(input int h, input int l, input bit odd, input string tag);
    int hh = (h == 0) ? 256 : h;
    int ll = (l == 0) ? 256 : l;
    for (int i = 0; i < hh; i++) begin
      exp_q.push_back(1'b1);           tag_q.push_back(tag);
      exp_q.push_back(!(odd && i == hh - 1)); tag_q.push_back(tag);
    end
    for (int i = 0; i < 2 * ll; i++) begin
      exp_q.push_back(1'b0); tag_q.push_back(tag);
    end
  endtask

  // Monitor: samples at mid-points of each half input cycle
  initial begin
    forever begin
      @(posedge clk); #2;
      if (mon_on) begin
        if (exp_q.size() == 0) check(clk_out, 1'b0, "queue-underflow");
        else check(clk_out, exp_q.pop_front(), tag_q.pop_front());
      end
      @(negedge clk); #2;
      if (mon_on) begin
        if (exp_q.size() == 0) check(clk_out, 1'b0, "queue-underflow");
        else check(clk_out, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic run_case(input int h1, input int l1, input bit o1, input int n1,
                          input int h2, input int l2, input bit o2, input int n2,
                          input int chg_at, input string tag);
    @(negedge clk);
    rst = 1'b1; hi_set = 8'(h1); lo_set = 8'(l1); odd_set = o1;
    repeat (2) @(negedge clk);
    #2 check(clk_out, 1'b0, "R1 reset state");
    @(negedge clk);
    rst = 1'b0;
    for (int p = 0; p < n1; p++) push_period(h1, l1, o1, tag);
    for (int p = 0; p < n2; p++) push_period(h2, l2, o2, tag);
    #3 mon_on = 1'b1;
    if (n2 > 0) begin
      repeat (chg_at) @(negedge clk);
      hi_set = 8'(h2); lo_set = 8'(l2); odd_set = o2;
    end
    wait (exp_q.size() == 0);
    mon_on = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    run_case(3, 2, 1'b0, 3, 0, 0, 1'b0, 0, 0, "R2/R3 even duty 3+2");
    run_case(2, 1, 1'b1, 3, 0, 0, 1'b0, 0, 0, "R6 odd 1.5/1.5");
    run_case(4, 3, 1'b1, 2, 0, 0, 1'b0, 0, 0, "R5 odd 4+3");
    run_case(1, 1, 1'b1, 2, 0, 0, 1'b0, 0, 0, "R5 odd 1+1");
    run_case(0, 1, 1'b0, 1, 1, 0, 1'b0, 1, 2, "R4 zero means 256");
    run_case(5, 5, 1'b0, 1, 1, 2, 1'b1, 2, 2, "R7 mid-period change");
    run_case(2, 2, 1'b0, 1, 3, 1, 1'b1, 2, 4, "R8 change at period end");

    // R1: reset asserted in the middle of a running period
    @(negedge clk);
    hi_set = 8'd6; lo_set = 8'd6; odd_set = 1'b0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #2 check(clk_out, 1'b0, "R1 mid-run reset");
      @(negedge clk); #2 check(clk_out, 1'b0, "R1 mid-run reset");
    end

    // R9: bypass follows the input clock
    @(negedge clk);
    rst = 1'b0; bypass = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #2 check(clk_out, 1'b1, "R9 bypass high half");
      @(negedge clk); #2 check(clk_out, 1'b0, "R9 bypass low half");
    end
    bypass = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule